// File: doc/BRIEF.md
# Synchronous Rectifier Ramp-In Controller

This block decides when the low-side rectifier switch of a synchronous buck stage may conduct while the converter starts into an output that is already charged. Until the soft-start level has climbed above the feedback level, no switching pulse is passed at all. Once switching begins, the high-side command passes straight through. The low side first conducts only in a narrow window at the very end of each switching period, after the inductor current has freewheeled through the body diode. Each period that carries a high-side pulse moves the low-side leading edge earlier by a fixed step of clock ticks. Conduction therefore widens until it meets the high-side falling edge, and from then on the two switches run fully complementary.

Switching-period timing arrives as a phase index from the modulator's ramp counter. The index counts clock ticks from 0 to `PERIOD_TICKS-1`, and a period closes on the tick where the index equals `PERIOD_TICKS-1`. The step per period is `ceil(PERIOD_TICKS / RAMP_CYCLES)` ticks, so the widening window covers a whole period within the ramp limit. A sequencer has four states: `ST_IDLE`, `ST_ARMED`, `ST_RAMP` and `ST_FULL`. Its transitions are T_ENABLE (idle to armed on `run_en`), T_START (armed to ramp at a period close with `ss_above_fb` high), T_ALIGN (ramp to full when the window has reached the high-side falling edge), T_CAP (ramp to full after `RAMP_CYCLES` periods) and T_STOP (any state to idle when `run_en` is low).

Top module: `sr_rampin`

## Requirements
- R1: After reset, and while `run_en` is high but no start has occurred, `hs_gate` and `ls_gate` stay low whatever `hs_cmd` does. The start (T_START) happens at the close of a period (`phase == PERIOD_TICKS-1`) in which `ss_above_fb` is sampled high, and gating begins with the next period.
- R2: In the first ramp period, `ls_gate` is high for exactly STEP ticks, at phases `PERIOD_TICKS-STEP` to `PERIOD_TICKS-1`. Between the high-side falling edge and that window both gates are low.
- R3: In the ramp, the window start for each period is `PERIOD_TICKS - W`, where W grows by STEP after every period that carried a high-side pulse, saturating at `PERIOD_TICKS`. `ls_gate` is only high on ticks where `hs_cmd` is low and a high-side pulse has already occurred in the same period.
- R4: At the close of a ramp period with a high-side pulse ending at phase E, the sequencer moves to full operation (T_ALIGN) when `PERIOD_TICKS - W <= E`.
- R5: The ramp lasts at most `RAMP_CYCLES` periods, skipped ones included. At the close of the `RAMP_CYCLES`-th ramp period, the sequencer moves to full operation (T_CAP).
- R6: In a ramp period with no high-side pulse, `ls_gate` stays low for the whole period and W is not advanced.
- R7: In full operation, `ls_gate` equals the inverse of `hs_cmd` on every tick, including periods with no high-side pulse (current sink allowed).
- R8: From the cycle after `run_en` is sampled low, both gates are low. The next start needs a new T_START and begins again with the STEP-wide window.
- R9: In ramp and full operation, `hs_gate` equals `hs_cmd` on every tick.
- R10: While reset is asserted, both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enable; low means shutdown or fault |
| ss_above_fb | input | 1 | Soft-start level is above the feedback level |
| phase | input | $clog2(PERIOD_TICKS) | Tick index within the switching period |
| hs_cmd | input | 1 | High-side command from the modulator |
| hs_gate | output | 1 | Gated high-side enable |
| ls_gate | output | 1 | Gated low-side enable |

## Verification
The ramp is driven with random high-side widths, and about one period in ten is skipped. This separates correct widening from widening that also advances on skipped periods, and shows whether a skipped period suppresses the low-side pulse. A ramp with wide pulses must end through the alignment rule. A ramp with narrow pulses that skips every other period cannot align, so it must end exactly at the period cap; this tells the two exit paths apart. Full-operation periods include skipped ones, which separates true complementary drive from ramp-style gating. A shutdown in the middle of a period, followed by a restart, shows that the narrow first window comes back.

// File: rtl/sr_rampin_pkg.sv
package sr_rampin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RAMP  = 2'd2,
        ST_FULL  = 2'd3
    } rr_state_e;
endpackage

// File: rtl/sr_rampin_track.sv
module sr_rampin_track #(
    parameter int PERIOD_TICKS = 300
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  period_end,
    input  logic                                  hs_cmd,
    input  logic [$clog2(PERIOD_TICKS)-1:0]       phase,
    output logic                                  seen_q,
    output logic                                  period_seen,
    output logic [$clog2(PERIOD_TICKS+1)-1:0]     fall_pos
);
    localparam int WW = $clog2(PERIOD_TICKS + 1);

    logic [WW-1:0] end_q;
    logic [WW-1:0] pos_next;

    assign pos_next    = WW'(phase) + WW'(1);
    assign period_seen = seen_q | hs_cmd;
    assign fall_pos    = hs_cmd ? pos_next : end_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            end_q  <= '0;
        end else if (period_end) begin
            seen_q <= 1'b0;
            end_q  <= '0;
        end else if (hs_cmd) begin
            seen_q <= 1'b1;
            end_q  <= pos_next;
        end
    end

    // a pulse seen inside a period is remembered for the low-side window (R3)
    p_seen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_cmd && !period_end) |=> seen_q);

    // a new period starts with no pulse recorded, so a skip is detectable (R6)
    p_seen_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !seen_q);
endmodule

// File: rtl/sr_rampin_width.sv
module sr_rampin_width #(
    parameter int PERIOD_TICKS = 300,
    parameter int RAMP_CYCLES  = 128
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear,
    input  logic                                  load,
    input  logic                                  advance,
    input  logic                                  seen,
    output logic [$clog2(PERIOD_TICKS+1)-1:0]     width,
    output logic                                  cap_next
);
    localparam int WW   = $clog2(PERIOD_TICKS + 1);
    localparam int CW   = $clog2(RAMP_CYCLES + 1);
    localparam int STEP = (PERIOD_TICKS + RAMP_CYCLES - 1) / RAMP_CYCLES;

    logic [CW-1:0] cyc_q;
    logic [WW:0]   sum;
    logic [WW-1:0] width_next;

    assign sum        = {1'b0, width} + (WW+1)'(STEP);
    assign width_next = (sum > (WW+1)'(PERIOD_TICKS)) ? WW'(PERIOD_TICKS) : sum[WW-1:0];
    assign cap_next   = (int'(cyc_q) + 1) >= RAMP_CYCLES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width <= '0;
            cyc_q <= '0;
        end else if (clear) begin
            width <= '0;
            cyc_q <= '0;
        end else if (load) begin
            width <= WW'(STEP);
            cyc_q <= '0;
        end else if (advance) begin
            if (int'(cyc_q) < RAMP_CYCLES) begin
                cyc_q <= cyc_q + CW'(1);
            end
            if (seen) begin
                width <= width_next;
            end
        end
    end

    p_load_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (width == WW'(STEP)));

    p_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && seen && !clear && !load && (int'(width) + STEP <= PERIOD_TICKS))
        |=> (int'(width) == int'($past(width)) + STEP));

    p_skip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !seen && !clear && !load) |=> $stable(width));

    p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cyc_q) <= RAMP_CYCLES);
endmodule

// File: rtl/sr_rampin_fsm.sv
module sr_rampin_fsm
    import sr_rampin_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_en,
    input  logic      ss_above_fb,
    input  logic      period_end,
    input  logic      aligned,
    input  logic      cap_next,
    output rr_state_e state,
    output logic      load,
    output logic      advance,
    output logic      clear
);
    rr_state_e next;

    always_comb begin
        next = state;
        if (!run_en) begin
            next = ST_IDLE;                               // T_STOP
        end else begin
            unique case (state)
                ST_IDLE:  next = ST_ARMED;                // T_ENABLE
                ST_ARMED: if (period_end && ss_above_fb) next = ST_RAMP;   // T_START
                ST_RAMP:  if (period_end && (aligned || cap_next)) next = ST_FULL; // T_ALIGN / T_CAP
                ST_FULL:  next = ST_FULL;
                default:  next = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_comb begin
        load    = 1'b0;
        advance = 1'b0;
        clear   = 1'b0;
        unique case (state)
            ST_IDLE:  clear   = 1'b1;
            ST_ARMED: load    = (next == ST_RAMP);
            ST_RAMP:  advance = period_end;
            ST_FULL:  ;
            default:  clear   = 1'b1;
        endcase
    end

    p_wait_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && run_en && !(period_end && ss_above_fb)) |=> (state == ST_ARMED));

    p_cap_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && run_en && period_end && cap_next) |=> (state == ST_FULL));

    p_align_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && run_en && period_end && aligned) |=> (state == ST_FULL));

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state == ST_IDLE));
endmodule

// File: rtl/sr_rampin.sv
module sr_rampin
    import sr_rampin_pkg::*;
#(
    parameter int PERIOD_TICKS = 300,
    parameter int RAMP_CYCLES  = 128
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run_en,
    input  logic                            ss_above_fb,
    input  logic [$clog2(PERIOD_TICKS)-1:0] phase,
    input  logic                            hs_cmd,
    output logic                            hs_gate,
    output logic                            ls_gate
);
    localparam int PW = $clog2(PERIOD_TICKS);
    localparam int WW = $clog2(PERIOD_TICKS + 1);

    rr_state_e     state;
    logic          period_end;
    logic          seen_q;
    logic          period_seen;
    logic [WW-1:0] fall_pos;
    logic [WW-1:0] width;
    logic [WW-1:0] win_start;
    logic          in_window;
    logic          aligned;
    logic          cap_next;
    logic          load;
    logic          advance;
    logic          clear;

    assign period_end = (phase == PW'(PERIOD_TICKS - 1));
    assign win_start  = WW'(PERIOD_TICKS) - width;
    assign in_window  = WW'(phase) >= win_start;
    assign aligned    = period_seen && (win_start <= fall_pos);

    sr_rampin_track #(.PERIOD_TICKS(PERIOD_TICKS)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_end  (period_end),
        .hs_cmd      (hs_cmd),
        .phase       (phase),
        .seen_q      (seen_q),
        .period_seen (period_seen),
        .fall_pos    (fall_pos)
    );

    sr_rampin_width #(.PERIOD_TICKS(PERIOD_TICKS), .RAMP_CYCLES(RAMP_CYCLES)) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load     (load),
        .advance  (advance),
        .seen     (period_seen),
        .width    (width),
        .cap_next (cap_next)
    );

    sr_rampin_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .ss_above_fb (ss_above_fb),
        .period_end  (period_end),
        .aligned     (aligned),
        .cap_next    (cap_next),
        .state       (state),
        .load        (load),
        .advance     (advance),
        .clear       (clear)
    );

    always_comb begin
        hs_gate = 1'b0;
        ls_gate = 1'b0;
        unique case (state)
            ST_IDLE, ST_ARMED: ;
            ST_RAMP: begin
                hs_gate = hs_cmd;
                ls_gate = !hs_cmd && seen_q && in_window;
            end
            ST_FULL: begin
                hs_gate = hs_cmd;
                ls_gate = !hs_cmd;
            end
            default: ;
        endcase
    end

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ls_gate |-> !hs_cmd);

    p_quiet_unstarted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ARMED) |-> (!hs_gate && !ls_gate));

    p_off_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!hs_gate && !ls_gate));

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (!hs_gate && !ls_gate);
        end
    end
endmodule

// File: tb/sr_rampin_test.sv
module sr_rampin_test;
    localparam int P    = 300;
    localparam int RC   = 128;
    localparam int STEP = (P + RC - 1) / RC;
    localparam int PW   = $clog2(P);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          ss_above_fb = 1'b0;
    logic [PW-1:0] phase = '0;
    logic          hs_cmd = 1'b0;
    logic          hs_gate;
    logic          ls_gate;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model: 0 idle, 1 armed, 2 ramp, 3 full
    int m_mode = 0;
    int m_w = 0;
    int m_cyc = 0;
    int last_exit = 0;   // 1 align, 2 cap

    always #4 clk = ~clk;

    sr_rampin #(.PERIOD_TICKS(P), .RAMP_CYCLES(RC)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ss_above_fb(ss_above_fb),
        .phase(phase), .hs_cmd(hs_cmd), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_hs(input int mode, input int d, input int p);
        return (mode >= 2) && (p < d);
    endfunction

    function automatic bit exp_ls(input int mode, input int w, input int d, input int p);
        if (mode == 2) return (d > 0) && (p >= d) && (p >= P - w);
        if (mode == 3) return !(p < d);
        return 1'b0;
    endfunction

    function automatic string mode_req(input int mode);
        if (mode == 2) return "R3";
        if (mode == 3) return "R7";
        return "R1";
    endfunction

    // one switching period with high-side width d (0 = skipped); returns ls tick count
    task automatic run_period(input int d, input bit ss, output int lsc);
        int bad_h = 0;
        int bad_l = 0;
        int mode0 = m_mode;
        lsc = 0;
        for (int p = 0; p < P; p++) begin
            @(negedge clk);
            run_en = 1'b1;
            phase = PW'(p);
            hs_cmd = (p < d);
            ss_above_fb = ss;
            #2;
            if (hs_gate !== exp_hs(mode0, d, p)) bad_h++;
            if (ls_gate !== exp_ls(mode0, m_w, d, p)) bad_l++;
            if (ls_gate === 1'b1) lsc++;
        end
        check(bad_h == 0, "R9", bad_h, 0);
        check(bad_l == 0, mode_req(mode0), bad_l, 0);
        if (m_mode == 1 && ss) begin
            m_mode = 2; m_w = STEP; m_cyc = 0;
        end else if (m_mode == 2) begin
            bit seen = (d > 0);
            bit hit = seen && ((P - m_w) <= d);
            if (seen) m_w = (m_w + STEP > P) ? P : m_w + STEP;
            m_cyc++;
            if (hit) begin m_mode = 3; last_exit = 1; end
            else if (m_cyc >= RC) begin m_mode = 3; last_exit = 2; end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lsc;
        int prev_lsc;
        int d;
        int k;
        void'($urandom(32'd4711));

        // R10: reset quiet with an active command
        hs_cmd = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        check(!hs_gate && !ls_gate, "R10", {hs_gate, ls_gate}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #2;
        check(!hs_gate && !ls_gate, "R10", {hs_gate, ls_gate}, 0);

        // R1: enabled but soft-start below feedback
        m_mode = 1;
        run_period(40, 1'b0, lsc);
        run_period(40, 1'b0, lsc);
        check(lsc == 0, "R1", lsc, 0);
        run_period(40, 1'b1, lsc);          // start decided at this close
        check(m_mode == 2 && lsc == 0, "R1", lsc, 0);

        // R2: narrow first window
        run_period(40, 1'b1, lsc);
        check(lsc == STEP, "R2", lsc, STEP);
        prev_lsc = lsc;

        // R3/R6/R4: random ramp with wide pulses
        k = 0;
        while (m_mode == 2 && k < 200) begin
            d = (($urandom % 10) == 0) ? 0 : 60 + int'($urandom % 61);
            run_period(d, 1'b1, lsc);
            if (d == 0) check(lsc == 0, "R6", lsc, 0);
            k++;
        end
        check(m_mode == 3 && last_exit == 1, "R4", last_exit, 1);

        // R7: full complementary, including skipped pulses
        for (int i = 0; i < 6; i++) begin
            d = (i % 3 == 0) ? 0 : 20 + int'($urandom % 100);
            run_period(d, 1'b1, lsc);
            check(lsc == P - d, "R7", lsc, P - d);
        end

        // R8: shutdown mid-period
        @(negedge clk);
        phase = PW'(5); hs_cmd = 1'b1; run_en = 1'b0;
        @(negedge clk); #2;
        check(!hs_gate && !ls_gate, "R8", {hs_gate, ls_gate}, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); hs_cmd = $urandom % 2; #2;
            check(!hs_gate && !ls_gate, "R8", {hs_gate, ls_gate}, 0);
        end
        m_mode = 1;
        run_period(30, 1'b1, lsc);
        check(lsc == 0, "R8", lsc, 0);
        run_period(30, 1'b1, lsc);
        check(lsc == STEP, "R8", lsc, STEP);

        // R5: narrow pulses, every other period skipped, cannot align
        k = 1;
        while (m_mode == 2) begin
            run_period((k % 2 == 0) ? 5 : 0, 1'b1, lsc);
            k++;
        end
        check(k == RC && last_exit == 2, "R5", k, RC);
        run_period(5, 1'b1, lsc);
        check(lsc == P - 5, "R5", lsc, P - 5);

        // R6 directed: skip then width unchanged in the following period
        @(negedge clk); run_en = 1'b0;
        m_mode = 0;
        @(negedge clk);
        m_mode = 1;
        run_period(50, 1'b1, lsc);
        run_period(50, 1'b1, lsc);          // W = STEP
        run_period(0, 1'b1, lsc);
        check(lsc == 0, "R6", lsc, 0);
        run_period(50, 1'b1, lsc);
        check(lsc == 2 * STEP, "R6", lsc, 2 * STEP);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule